// File: doc/BRIEF.md
# Multi-Route Delayed Trigger Fan-Out

This block turns one command strobe into a single pulse on each of several output routes, each route delayed by its own programmable number of synchronization-clock periods. It lets one trigger reach several destinations at chosen relative times. Every route has its own sync tick input: a one-cycle enable, in the main clock domain, that marks an active edge of that route's synchronization clock. All delays and pulse widths are counted in those ticks.

When a command is accepted, the block copies each route's delay and enable bit into internal state. Every enabled route then counts its own ticks and fires. Delivery is always synchronous to the route's ticks; the block has no asynchronous pass-through path. While any route is still counting or pulsing, the block reports busy and ignores new commands.

Top module: `trig_fanout`

## Requirements
- R1: After synchronous reset, every pulse output and the busy output are low.
- R2: An accepted command produces exactly one pulse on each route whose enable bit `route_en[i]` was 1 at acceptance. Routes whose enable bit was 0 stay low.
- R3: Route i takes its delay from `delay_i[4*i+3:4*i]`, giving a value d from 0 to 15. Its pulse rises on the clock edge of the (d+1)-th sync tick of that route after the acceptance edge. With d = 0 it rises on the first such tick.
- R4: Once a pulse is high, it stays high until the route's next sync tick and falls on that tick. The pulse width is one period of the route's sync clock.
- R5: Routes count independently. Each route uses only its own delay and its own sync tick stream.
- R6: A command is accepted on an edge where `cmd` is high and busy is low. Busy is high from the edge after acceptance until every enabled route's pulse has ended. A command arriving while busy is high is ignored.
- R7: Delay and enable inputs are sampled only at acceptance. Changing them while busy does not alter a trigger in progress.
- R8: A sync tick present in the same cycle as the accepted command is not counted.
- R9: An accepted command with no route enabled produces no pulse, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 1 | Command strobe |
| delay_i | input | ROUTES*DLY_W | Packed per-route delay values, route i at bits 4i+3:4i |
| route_en | input | ROUTES | Per-route enable bits |
| sync_en | input | ROUTES | Per-route sync-clock tick enables |
| pulse_o | output | ROUTES | Per-route trigger pulse, registered |
| busy_o | output | 1 | High while any route is counting or pulsing |

## Verification
The hardest situation to reach is a mixture of inputs arriving while a trigger is in progress. It needs several routes in different phases at once: one still counting, one pulsing, one finished. Inside that window a second command must arrive and the delay inputs must change. The stimulus reaches it with random, sparse sync ticks per route, so that routes drift apart. Delays and enables are re-drawn every cycle, and random commands land inside busy windows. Directed cases add a tick on the acceptance edge, delays 0 and 15, and a command with all routes disabled.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int DLY_W_DEF  = 4;
  localparam int ROUTES_DEF = 4;

  // per-route phase
  typedef enum logic [1:0] {
    RT_IDLE = 2'd0,
    RT_WAIT = 2'd1,
    RT_HIGH = 2'd2
  } rt_phase_t;
endpackage

// File: rtl/trig_route.sv
module trig_route
  import trig_pkg::*;
#(
  parameter int DLY_W = DLY_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             en_in,
  input  logic [DLY_W-1:0] dly_in,
  input  logic             tick,
  output logic             active,
  output logic             pulse
);
  rt_phase_t        st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             pulse_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (load) begin
      st_d  = en_in ? RT_WAIT : RT_IDLE;
      cnt_d = dly_in;
    end else if (tick) begin
      unique case (st_q)
        RT_WAIT: begin
          if (cnt_q == '0) st_d = RT_HIGH;
          else             cnt_d = cnt_q - 1'b1;
        end
        RT_HIGH: st_d = RT_IDLE;
        default: st_d = RT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= RT_IDLE;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      pulse_q <= (st_d == RT_HIGH);
    end
  end

  assign active = (st_q != RT_IDLE);
  assign pulse  = pulse_q;
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl #(
  parameter int ROUTES = trig_pkg::ROUTES_DEF
) (
  input  logic              cmd,
  input  logic [ROUTES-1:0] active,
  output logic              accept,
  output logic              busy
);
  assign busy   = |active;
  assign accept = cmd & ~busy;
endmodule

// File: rtl/trig_fanout.sv
module trig_fanout
  import trig_pkg::*;
#(
  parameter int ROUTES = ROUTES_DEF,
  parameter int DLY_W  = DLY_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd,
  input  logic [ROUTES*DLY_W-1:0] delay_i,
  input  logic [ROUTES-1:0]       route_en,
  input  logic [ROUTES-1:0]       sync_en,
  output logic [ROUTES-1:0]       pulse_o,
  output logic                    busy_o
);
  logic [ROUTES-1:0] active;
  logic              accept;

  trig_ctrl #(.ROUTES(ROUTES)) u_ctrl (
    .cmd    (cmd),
    .active (active),
    .accept (accept),
    .busy   (busy_o)
  );

  for (genvar g = 0; g < ROUTES; g++) begin : g_rt
    trig_route #(.DLY_W(DLY_W)) u_rt (
      .clk    (clk),
      .rst    (rst),
      .load   (accept),
      .en_in  (route_en[g]),
      .dly_in (delay_i[g*DLY_W +: DLY_W]),
      .tick   (sync_en[g]),
      .active (active[g]),
      .pulse  (pulse_o[g])
    );
  end
endmodule

// File: rtl/trig_fanout_chk.sv
module trig_fanout_chk #(
  parameter int ROUTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd,
  input logic              accept,
  input logic [ROUTES-1:0] sync_en,
  input logic [ROUTES-1:0] pulse_o,
  input logic              busy_o
);
  // R6
  pulse_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_o != '0) |-> busy_o);

  // R6
  accept_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> (!busy_o && cmd));

  // R6
  busy_ends_on_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> ($past(pulse_o) != '0));

  for (genvar g = 0; g < ROUTES; g++) begin : g_c
    // R4
    pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !sync_en[g] |=> $stable(pulse_o[g]));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      (pulse_o[g] && sync_en[g]) |=> !pulse_o[g]);
  end
endmodule

bind trig_fanout trig_fanout_chk #(.ROUTES(ROUTES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cmd     (cmd),
  .accept  (accept),
  .sync_en (sync_en),
  .pulse_o (pulse_o),
  .busy_o  (busy_o)
);

// File: tb/sim_trig_fanout.sv
module sim_trig_fanout;
  localparam int NR = 4;
  localparam int DW = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd = 1'b0;
  logic [NR*DW-1:0] delay_i = '0;
  logic [NR-1:0]    route_en = '0;
  logic [NR-1:0]    sync_en = '0;
  logic [NR-1:0]    pulse_o;
  logic             busy_o;

  int total = 0;
  int bad   = 0;
  int ticks [NR];
  int ld    [NR];
  bit le    [NR];

  always #2.5 clk = ~clk;

  trig_fanout #(.ROUTES(NR), .DLY_W(DW)) u0 (
    .clk(clk), .rst(rst), .cmd(cmd), .delay_i(delay_i),
    .route_en(route_en), .sync_en(sync_en), .pulse_o(pulse_o), .busy_o(busy_o)
  );

  function automatic bit exp_pulse(int i);
    return le[i] && (ticks[i] == ld[i] + 1);
  endfunction

  function automatic bit exp_busy();
    bit b = 0;
    for (int i = 0; i < NR; i++) if (le[i] && ticks[i] < ld[i] + 2) b = 1;
    return b;
  endfunction

  task automatic chk(bit act, bit exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit c, logic [NR*DW-1:0] d, logic [NR-1:0] e,
                      logic [NR-1:0] s, string tag);
    bit acc;
    cmd = c; delay_i = d; route_en = e; sync_en = s;
    acc = c && !exp_busy();
    @(posedge clk);
    for (int i = 0; i < NR; i++) begin
      if (acc) begin
        ticks[i] = 0; ld[i] = int'(d[i*DW +: DW]); le[i] = e[i];
      end else if (s[i] && ticks[i] < 100) ticks[i]++;
    end
    @(negedge clk);
    for (int i = 0; i < NR; i++) chk(pulse_o[i], exp_pulse(i), tag);
    chk(busy_o, exp_busy(), "R6");
  endtask

  task automatic idle_out(logic [NR-1:0] s, string tag);
    for (int k = 0; k < 60 && exp_busy(); k++) step(0, '0, '0, s, tag);
    step(0, '0, '0, '1, tag);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NR; i++) begin ticks[i] = 100; ld[i] = 0; le[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(busy_o, 1'b0, "R1");
    for (int i = 0; i < NR; i++) chk(pulse_o[i], 1'b0, "R1");

    // R3 R8 all delays 0, tick on accept edge not counted
    step(1, '0, '1, '1, "R8");
    idle_out('1, "R3");
    // R3 max delay 15 on every route, continuous ticks
    step(1, {NR{4'hF}}, '1, '1, "R3");
    idle_out('1, "R3");
    // R5 distinct delays, distinct tick patterns
    step(1, 16'h3120, '1, '0, "R5");
    for (int k = 0; k < 40; k++) step(0, '0, '0, 4'b0001 | {3'b0, 1'b0} | 4'(k % 3 == 0 ? 2 : 0) | 4'(k[0] ? 12 : 0), "R5");
    idle_out('1, "R5");
    // R9 no route enabled
    step(1, 16'h1111, '0, '1, "R9");
    chk(busy_o, 1'b0, "R9");
    // R6 R7 second command and new delays while busy
    step(1, 16'h5555, 4'b1010, '0, "R6");
    step(1, 16'h0000, 4'b1111, '1, "R7");
    for (int k = 0; k < 10; k++) step(1, 16'hFFFF, '1, '1, "R7");
    idle_out('1, "R2");

    // random
    for (int k = 0; k < 3000; k++) begin
      logic [NR-1:0] s;
      s = NR'($urandom) & NR'($urandom);
      step(($urandom % 8) == 0, (NR*DW)'($urandom), NR'($urandom), s, "R2");
    end
    idle_out('1, "R2");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule